// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a synchronous two-wire serial slave that gives a bus master read and write access to a bank of sixteen 8-bit registers. The clock and data lines are oversampled by the system clock. The system clock must run at least sixteen times faster than the bus clock. The block never drives the data line high. Its only bus output is an enable that pulls the line low, which suits an open-drain pad with an external pull-up.

A transfer opens with a START. The first byte carries a 7-bit device address, fixed at 0x4C, and a direction bit. In a write, the next byte sets an internal register pointer and every byte after it is stored at the pointer, which then advances. A read returns the register under the pointer. The pointer is normally set first by a short write, which the master then joins to the read through a repeated START. The block acknowledges every byte it receives. It follows the master's acknowledge during reads to decide whether to send another byte.

The bus side is a plain pin interface with no valid/ready stream. Each bit is paced only by the master's clock, so the block cannot apply back-pressure, and it never stretches the clock.

Top module: `i2c_regbank_slave`

## Requirements
- R1: A rising data line while the clock is high (STOP) returns the block to idle with the data line released. It then waits for a START.
- R2: A falling data line while the clock is high (START) begins address reception at any point, including in the middle of a transfer (repeated START). A write pointer byte in progress is then discarded.
- R3: An address byte whose upper seven bits are 0x4C is acknowledged by pulling the data line low during the ninth clock pulse. Any other address gets no acknowledge, and the block then stays silent until the next START or STOP.
- R4: In a write, the first byte after the address loads the register pointer from its low four bits. Each further byte is stored in the register at the pointer. Every received byte is acknowledged.
- R5: After each stored write byte the pointer advances by one, wrapping from 15 to 0.
- R6: In a read (direction bit 1), the block sends the register at the pointer most significant bit first, changing the data line only while the clock is low. It releases the line during the master's acknowledge pulse.
- R7: After each byte sent, the pointer advances by one, wrapping from 15 to 0. A master acknowledge (line low) makes the block send the next register. A master non-acknowledge (line high) releases the line and returns the block to idle.
- R8: The pull-low enable changes only while the synchronized clock line is low.
- R9: After reset all registers and the pointer are 0 and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | When 1, the pad pulls the data line low |

## Verification
A stored write byte, its acknowledge drive and the pointer wrap all happen in the same system clock cycle. The test provokes this by starting a burst write at register 14, so that the byte for register 15 commits at the same moment the pointer rolls to 0 and the acknowledge is raised. The test judges the result by the acknowledges seen on the line and by reading registers 14, 15 and 0 back in one burst read. That read also places a pointer wrap in the same cycle as the loading of the next transmit byte, and the returned values and their order must match.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } slv_state_e;
endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o,
  output logic [LINES-1:0] prev_o
);
  logic [LINES-1:0] chain_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '1;
          else        chain_q[s] <= async_i;
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain_q[s] <= '1;
          else        chain_q[s] <= chain_q[s-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_o <= '1;
    else        prev_o <= chain_q[STAGES-1];

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_held_hi;
  assign scl_held_hi = scl_s & scl_p;
  assign start_o = scl_held_hi & sda_p & ~sda_s;
  assign stop_o  = scl_held_hi & ~sda_p & sda_s;
  assign rise_o  = scl_s & ~scl_p;
  assign fall_o  = ~scl_s & scl_p;
endmodule

// File: rtl/i2c_rs_regfile.sv
module i2c_rs_regfile #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  genvar e;
  generate
    for (e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n)                               mem_q[e] <= '0;
        else if (we_i && (waddr_i == AW'(e)))     mem_q[e] <= wdata_i;
    end
  endgenerate

  assign rdata_o = mem_q[raddr_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (mem_q[$past(waddr_i)] == $past(wdata_i))); // R4
endmodule

// File: rtl/i2c_rs_engine.sv
module i2c_rs_engine
  import i2c_rs_pkg::*;
#(
  parameter int          ADDR_W   = 7,
  parameter int          DATA_W   = 8,
  parameter int          DEPTH    = 16,
  parameter logic [6:0]  DEV_ADDR = 7'h4C,
  localparam int         PTR_W    = $clog2(DEPTH),
  localparam int         CNT_W    = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic [DATA_W-1:0] rd_data,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              pull_o
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DATA_W);

  slv_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic [PTR_W-1:0]  ptr_q, ptr_d;
  logic              first_q, first_d;
  logic              rw_q, rw_d;
  logic              acked_q, acked_d;
  logic              oe_q, oe_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    first_d = first_q;
    rw_d    = rw_q;
    acked_d = acked_q;
    oe_d    = oe_q;
    reg_we  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            if (sh_q[DATA_W-1 -: ADDR_W] == DEV_ADDR) begin
              state_d = ST_ADDR_ACK;
              rw_d    = sh_q[0];
              oe_d    = 1'b1;
            end else begin
              state_d = ST_IGNORE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            cnt_d = '0;
            if (rw_q) begin
              state_d = ST_RD_BYTE;
              sh_d    = rd_data;
              ptr_d   = ptr_q + 1'b1;
              oe_d    = ~rd_data[DATA_W-1];
            end else begin
              state_d = ST_WR_BYTE;
              first_d = 1'b1;
              oe_d    = 1'b0;
            end
          end
        end
        ST_WR_BYTE: begin
          if (scl_rise) begin
            sh_d  = {sh_q[DATA_W-2:0], sda_lvl};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            state_d = ST_WR_ACK;
            oe_d    = 1'b1;
            if (first_q) begin
              ptr_d   = sh_q[PTR_W-1:0];
              first_d = 1'b0;
            end else begin
              reg_we = 1'b1;
              ptr_d  = ptr_q + 1'b1;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            state_d = ST_WR_BYTE;
            cnt_d   = '0;
            oe_d    = 1'b0;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (cnt_q == LAST_BIT) begin
              state_d = ST_RD_ACK;
              oe_d    = 1'b0;
            end else begin
              sh_d  = {sh_q[DATA_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
              oe_d  = ~sh_q[DATA_W-2];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            acked_d = ~sda_lvl;
          end else if (scl_fall) begin
            if (acked_q) begin
              state_d = ST_RD_BYTE;
              cnt_d   = '0;
              sh_d    = rd_data;
              ptr_d   = ptr_q + 1'b1;
              oe_d    = ~rd_data[DATA_W-1];
            end else begin
              state_d = ST_IDLE;
              oe_d    = 1'b0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      first_q <= 1'b0;
      rw_q    <= 1'b0;
      acked_q <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      first_q <= first_d;
      rw_q    <= rw_d;
      acked_q <= acked_d;
      oe_q    <= oe_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign reg_wdata = sh_q;
  assign pull_o    = oe_q;

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q)); // R1
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det) |=> (state_q == ST_ADDR && cnt_q == '0)); // R2
  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !oe_q); // R3
  AST_WRITE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> oe_q); // R4
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && ptr_q == '1) |=> (ptr_q == '0)); // R5
  AST_MASTER_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK) |-> !oe_q); // R6
  AST_PULL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> !scl_lvl); // R8
endmodule

// File: rtl/i2c_regbank_slave.sv
module i2c_regbank_slave #(
  parameter int         ADDR_W      = 7,
  parameter int         DATA_W      = 8,
  parameter int         DEPTH       = 16,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h4C
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [1:0] line_s, line_p;
  logic start_w, stop_w, rise_w, fall_w;
  logic [PTR_W-1:0]  ptr_w;
  logic              we_w;
  logic [DATA_W-1:0] wdata_w, rdata_w;

  i2c_rs_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (line_s),
    .prev_o  (line_p)
  );

  i2c_rs_cond u_cond (
    .scl_s   (line_s[1]),
    .scl_p   (line_p[1]),
    .sda_s   (line_s[0]),
    .sda_p   (line_p[0]),
    .start_o (start_w),
    .stop_o  (stop_w),
    .rise_o  (rise_w),
    .fall_o  (fall_w)
  );

  i2c_rs_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .DEV_ADDR(DEV_ADDR)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (line_s[1]),
    .sda_lvl   (line_s[0]),
    .start_det (start_w),
    .stop_det  (stop_w),
    .scl_rise  (rise_w),
    .scl_fall  (fall_w),
    .rd_data   (rdata_w),
    .ptr_o     (ptr_w),
    .reg_we    (we_w),
    .reg_wdata (wdata_w),
    .pull_o    (sda_pull_o)
  );

  i2c_rs_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (we_w),
    .waddr_i (ptr_w),
    .wdata_i (wdata_w),
    .raddr_i (ptr_w),
    .rdata_o (rdata_w)
  );

  AST_RESET_RELEASED: assert property (@(posedge clk)
    !rst_n |=> !sda_pull_o); // R9
endmodule

// File: tb/i2c_regbank_slave_bench.sv
module i2c_regbank_slave_bench;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_pull;
  logic sda_line;
  int total = 0;
  int bad = 0;
  int oe_viol = 0;
  bit done = 1'b0;
  logic prev_pull = 1'b0;

  always #5 clk = ~clk;
  assign sda_line = m_sda & ~sda_pull;

  i2c_regbank_slave u_i2c_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_pull_o(sda_pull)
  );

  always @(negedge clk) begin
    if (rst_n && (sda_pull !== prev_pull) && m_scl) oe_viol++;
    prev_pull <= sda_pull;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic clock_bit(input bit b, output bit seen);
    m_sda = b; tick(Q);
    m_scl = 1'b1; tick(Q);
    seen = sda_line;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    bit s;
    for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
    clock_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input bit give_ack, output logic [7:0] v);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      clock_bit(1'b1, s);
      v[i] = s;
    end
    clock_bit(~give_ack, s);
  endtask

  task automatic t_reset();
    bit a;
    logic [7:0] v;
    check(sda_pull == 1'b0, "R9 pull released after reset", sda_pull, 0);
    bus_start();
    put_byte(8'h98, a);
    bus_start();
    put_byte(8'h99, a);
    get_byte(1'b0, v);
    bus_stop();
    check(v == 8'h00, "R9 register 0 after reset", v, 0);
  endtask

  task automatic t_write_read();
    bit a0, a1, a2;
    logic [7:0] v;
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h03, a1);
    put_byte(8'hA5, a2);
    bus_stop();
    check(a0, "R3 address 0x4C acknowledged", a0, 1);
    check(a1 && a2, "R4 pointer and data acknowledged", {a1, a2}, 3);
    check(sda_pull == 1'b0, "R1 released after STOP", sda_pull, 0);
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h03, a1);
    bus_start();
    put_byte(8'h99, a2);
    get_byte(1'b0, v);
    check(v == 8'hA5, "R6 read returns stored byte", v, 8'hA5);
    tick(Q);
    check(sda_line == 1'b1 && sda_pull == 1'b0, "R7 NACK releases line", sda_pull, 0);
    bus_stop();
  endtask

  task automatic t_burst_wrap();
    bit a0, a1, a2, a3, a4;
    logic [7:0] v0, v1, v2, v3;
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h0E, a1);
    put_byte(8'h11, a2);
    put_byte(8'h22, a3);
    put_byte(8'h33, a4);
    bus_stop();
    check(a2 && a3 && a4, "R5 burst bytes acknowledged", {a2, a3, a4}, 7);
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h1E, a1);
    bus_start();
    put_byte(8'h99, a0);
    get_byte(1'b1, v0);
    get_byte(1'b1, v1);
    get_byte(1'b0, v2);
    bus_stop();
    check(v0 == 8'h11, "R5 register 14", v0, 8'h11);
    check(v1 == 8'h22, "R5 register 15", v1, 8'h22);
    check(v2 == 8'h33, "R5 wrap to register 0", v2, 8'h33);
    bus_start();
    put_byte(8'h99, a0);
    get_byte(1'b0, v3);
    bus_stop();
    check(v3 == 8'h00, "R7 pointer advanced to register 1", v3, 0);
  endtask

  task automatic t_mismatch();
    bit a0, a1, a2;
    logic [7:0] v;
    bus_start();
    put_byte(8'h9A, a0);
    put_byte(8'h03, a1);
    put_byte(8'hFF, a2);
    check(!a0, "R3 foreign address not acknowledged", a0, 0);
    check(!a1 && !a2, "R3 later bytes ignored", {a1, a2}, 0);
    bus_stop();
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h03, a1);
    bus_start();
    put_byte(8'h99, a2);
    get_byte(1'b0, v);
    bus_stop();
    check(v == 8'hA5, "R3 register untouched by foreign transfer", v, 8'hA5);
  endtask

  task automatic t_restart();
    bit a0, a1, a2;
    logic [7:0] v5, v6;
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h05, a1);
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h06, a1);
    put_byte(8'h77, a2);
    bus_stop();
    check(a0 && a1 && a2, "R2 restarted write acknowledged", {a0, a1, a2}, 7);
    bus_start();
    put_byte(8'h98, a0);
    put_byte(8'h05, a1);
    bus_start();
    put_byte(8'h99, a2);
    get_byte(1'b1, v5);
    get_byte(1'b0, v6);
    bus_stop();
    check(v5 == 8'h00, "R2 register 5 untouched", v5, 0);
    check(v6 == 8'h77, "R2 register 6 written after restart", v6, 8'h77);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_read();
    t_burst_wrap();
    t_mismatch();
    t_restart();
    check(oe_viol == 0, "R8 pull changes only with clock low", oe_viol, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule